// File: doc/BRIEF.md
# Pipelined Incrementing Burst Master

This block is the bus-side engine of a local requester that needs to move a short run of consecutive data over a pipelined address/data bus of the AHB-Lite kind. A single command carries a start address, a beat size (byte, halfword or word), a direction and a burst kind: four, eight or sixteen beats, or an open-length run whose beat count comes with the command. The master then drives every beat address itself, stepping by the beat size in bytes. The first beat is driven NONSEQ and the later beats SEQ, and each address phase overlaps the data phase of the beat before it.

While the slave stretches a data phase with HREADY low, the master freezes the next address phase and all of its control signals, and keeps the write data unchanged. It keeps track of which accepted address the current data phase belongs to. Read beats are handed back on a strobe in the same cycle they complete. Write beats are taken from the requester one at a time through a pop strobe.

A two-cycle ERROR response ends the burst early. A command that would run past a 1 KB address boundary, that asks for a beat wider than the data bus, or that asks for an open-length run of zero beats is refused without touching the bus. Every command, whether finished, aborted or refused, ends with one done pulse that carries an error flag.

Top module: `burst_master`

## Requirements
- R1: The address of beat k of a burst is the start address plus k times 2^size bytes, where size is cmd_size (0 byte, 1 halfword, 2 word). The beats appear in increasing k, so an INCR4 halfword burst from 0x34 drives 0x34, 0x36, 0x38, 0x3A.
- R2: The number of beats is set by cmd_kind: 1 gives 4, 2 gives 8, 3 gives 16, and 0 gives cmd_count beats. cmd_count has no effect for kinds 1 to 3. Every beat drives hburst = {cmd_kind,1}, that is 1, 3, 5 or 7, together with hsize = cmd_size and hwrite = cmd_write.
- R3: In a cycle with hready low and an OKAY response, the address phase on the bus (haddr, htrans, hsize, hburst, hwrite) and hwdata hold their values into the next cycle.
- R4: A write beat raises wr_pop in the cycle its address is accepted, and hwdata carries the wr_data of that cycle from the next cycle until the data phase completes. A read beat raises rd_valid, with rd_data equal to hrdata, in the cycle its data phase completes with OKAY.
- R5: cmd_ready is high only when no address phase and no data phase is in progress. A command is taken in a cycle where cmd_valid and cmd_ready are both high.
- R6: htrans is NONSEQ (2'b10) for the first beat, SEQ (2'b11) for every later beat, and IDLE (2'b00) when no beat is pending. The first beat appears in the cycle after the command is taken.
- R7: In the first cycle of an ERROR response (hresp high, hready low), the master drives IDLE in the following cycle. It issues no further beats, and the burst ends with done_err high.
- R8: A command whose bytes would extend past the next 1 KB boundary is refused: no beat reaches the bus, and done_valid with done_err is high in the cycle after the command is taken. A burst that ends exactly at the boundary is accepted.
- R9: A command with a beat wider than the data bus (cmd_size 3 at 32 bits), or an open-length command with cmd_count 0, is refused in the same way as R8.
- R10: After a burst whose last data phase completes with OKAY, done_valid is high with done_err low for exactly one cycle, the cycle after that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master can take a command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_size | input | 2 | Beat size code, 2^size bytes |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_kind | input | 2 | 0 open length, 1 four, 2 eight, 3 sixteen beats |
| cmd_count | input | CNT_W | Beat count for open-length commands |
| wr_data | input | DATA_W | Write data for the next write beat |
| wr_pop | output | 1 | wr_data taken this cycle |
| rd_valid | output | 1 | Read beat returned this cycle |
| rd_data | output | DATA_W | Read beat data |
| done_valid | output | 1 | Command finished, one-cycle pulse |
| done_err | output | 1 | Command refused or ended by error |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst kind |
| hwrite | output | 1 | Transfer direction |
| hwdata | output | DATA_W | Bus write data |
| hrdata | input | DATA_W | Bus read data |
| hready | input | 1 | Transfer done / not stretched |
| hresp | input | 1 | Error response |

## Verification
The first beat address appears one cycle after the command is taken. Each later beat appears one cycle after the hready-high edge that accepted the beat before it. A beat's data completes in the first hready-high cycle after its address was accepted. wr_pop and rd_valid are combinational and are due in the accepting or completing cycle itself, while done_valid follows the last completion, or the refused command, by exactly one cycle. The bench drives the slave replies just after each rising edge and samples every output at the falling edge. It keeps its own beat index to know which address each data phase belongs to, and compares cycle numbers to confirm the one-cycle offsets of the done pulse.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } trans_e;

   typedef enum logic [1:0] {
      BK_OPEN = 2'd0,
      BK_X4   = 2'd1,
      BK_X8   = 2'd2,
      BK_X16  = 2'd3
   } kind_e;
endpackage

// File: rtl/burst_planner.sv
module burst_planner
   import burst_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 5,
   parameter int BOUND_LOG2 = 10
) (
   input  logic [BOUND_LOG2-1:0] offs,
   input  logic [1:0]            size,
   input  logic [1:0]            kind,
   input  logic [CNT_W-1:0]      count,
   output logic [CNT_W-1:0]      beats,
   output logic                  refuse
);
   localparam int SW     = BOUND_LOG2 + CNT_W + 4;
   localparam int MAX_SZ = $clog2(DATA_W / 8);
   localparam logic [SW-1:0] LIMIT = SW'(1) << BOUND_LOG2;

   logic [SW-1:0] span;

   always_comb begin
      case (kind_e'(kind))
         BK_X4:   beats = CNT_W'(4);
         BK_X8:   beats = CNT_W'(8);
         BK_X16:  beats = CNT_W'(16);
         default: beats = count;
      endcase
      span   = SW'(offs) + (SW'(beats) << size);
      refuse = (32'(size) > MAX_SZ) || (beats == '0) || (span > LIMIT);
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hready,
   input  logic              start,
   input  logic              abort,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [1:0]        st_size,
   input  logic [1:0]        st_kind,
   input  logic              st_write,
   input  logic [CNT_W-1:0]  st_beats,
   output logic [ADDR_W-1:0] haddr,
   output logic [1:0]        htrans,
   output logic [2:0]        hsize,
   output logic [2:0]        hburst,
   output logic              hwrite,
   output logic              ap_valid
);
   trans_e             trans_q;
   logic [CNT_W-1:0]   left_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [2:0]         size_q;
   logic [1:0]         kind_q;
   logic               write_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trans_q <= TR_IDLE;
         left_q  <= '0;
         addr_q  <= '0;
         size_q  <= '0;
         kind_q  <= '0;
         write_q <= 1'b0;
      end else if (abort) begin
         trans_q <= TR_IDLE;
         left_q  <= '0;
      end else if (start) begin
         trans_q <= TR_NONSEQ;
         left_q  <= st_beats;
         addr_q  <= st_addr;
         size_q  <= {1'b0, st_size};
         kind_q  <= st_kind;
         write_q <= st_write;
      end else if (hready && trans_q != TR_IDLE) begin
         if (left_q > CNT_W'(1)) begin
            trans_q <= TR_SEQ;
            left_q  <= left_q - CNT_W'(1);
            addr_q  <= addr_q + (ADDR_W'(1) << size_q);
         end else begin
            trans_q <= TR_IDLE;
            left_q  <= '0;
         end
      end
   end

   assign haddr    = addr_q;
   assign htrans   = trans_q;
   assign hsize    = size_q;
   assign hburst   = {kind_q, 1'b1};
   assign hwrite   = write_q;
   assign ap_valid = (trans_q != TR_IDLE);
endmodule

// File: rtl/burst_data_track.sv
module burst_data_track #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hready,
   input  logic              hresp,
   input  logic              ap_valid,
   input  logic              ap_write,
   input  logic              refuse_now,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] hrdata,
   output logic              dp_active,
   output logic              abort,
   output logic              wr_pop,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] hwdata,
   output logic              done_valid,
   output logic              done_err
);
   logic              dp_q;
   logic              dp_wr_q;
   logic [DATA_W-1:0] wdat_q;
   logic              last_done;

   assign last_done = dp_q && hready && !ap_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_q       <= 1'b0;
         dp_wr_q    <= 1'b0;
         wdat_q     <= '0;
         done_valid <= 1'b0;
         done_err   <= 1'b0;
      end else begin
         if (hready) begin
            dp_q    <= ap_valid;
            dp_wr_q <= ap_write;
         end
         if (wr_pop)
            wdat_q <= wr_data;
         done_valid <= refuse_now || last_done;
         done_err   <= refuse_now || (last_done && hresp);
      end
   end

   assign dp_active = dp_q;
   assign abort     = dp_q && hresp && !hready;
   assign wr_pop    = hready && ap_valid && ap_write;
   assign rd_valid  = dp_q && !dp_wr_q && hready && !hresp;
   assign rd_data   = hrdata;
   assign hwdata    = wdat_q;
endmodule

// File: rtl/burst_master.sv
module burst_master #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 5,
   parameter int BOUND_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [1:0]        cmd_size,
   input  logic              cmd_write,
   input  logic [1:0]        cmd_kind,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_pop,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              done_valid,
   output logic              done_err,
   output logic [ADDR_W-1:0] haddr,
   output logic [1:0]        htrans,
   output logic [2:0]        hsize,
   output logic [2:0]        hburst,
   output logic              hwrite,
   output logic [DATA_W-1:0] hwdata,
   input  logic [DATA_W-1:0] hrdata,
   input  logic              hready,
   input  logic              hresp
);
   generate
      if (CNT_W < 5) begin : g_bad_cnt
         $error("CNT_W must hold a count of sixteen beats");
      end
      if (DATA_W < 8 || DATA_W > 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("DATA_W must be a power of two from 8 to 64");
      end
      if (BOUND_LOG2 < 6 || BOUND_LOG2 >= ADDR_W) begin : g_bad_bound
         $error("BOUND_LOG2 must lie inside the address");
      end
   endgenerate

   logic [CNT_W-1:0] beats;
   logic             refuse;
   logic             take;
   logic             ap_valid;
   logic             dp_active;
   logic             abort;

   burst_planner #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .BOUND_LOG2(BOUND_LOG2)
   ) u_plan (
      .offs(cmd_addr[BOUND_LOG2-1:0]), .size(cmd_size), .kind(cmd_kind),
      .count(cmd_count), .beats(beats), .refuse(refuse)
   );

   assign cmd_ready = !ap_valid && !dp_active;
   assign take      = cmd_valid && cmd_ready;

   burst_addr_gen #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) u_addr (
      .clk(clk), .rst_n(rst_n), .hready(hready),
      .start(take && !refuse), .abort(abort),
      .st_addr(cmd_addr), .st_size(cmd_size), .st_kind(cmd_kind),
      .st_write(cmd_write), .st_beats(beats),
      .haddr(haddr), .htrans(htrans), .hsize(hsize), .hburst(hburst),
      .hwrite(hwrite), .ap_valid(ap_valid)
   );

   burst_data_track #(
      .DATA_W(DATA_W)
   ) u_data (
      .clk(clk), .rst_n(rst_n), .hready(hready), .hresp(hresp),
      .ap_valid(ap_valid), .ap_write(hwrite), .refuse_now(take && refuse),
      .wr_data(wr_data), .hrdata(hrdata),
      .dp_active(dp_active), .abort(abort), .wr_pop(wr_pop),
      .rd_valid(rd_valid), .rd_data(rd_data), .hwdata(hwdata),
      .done_valid(done_valid), .done_err(done_err)
   );
endmodule

// File: rtl/burst_master_chk.sv
module burst_master_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic [ADDR_W-1:0] haddr,
   input logic [1:0]        htrans,
   input logic [2:0]        hsize,
   input logic [2:0]        hburst,
   input logic              hwrite,
   input logic [DATA_W-1:0] hwdata,
   input logic              hready,
   input logic              hresp
);
   AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && htrans != 2'b00 && !hresp) |=>
      ($stable(haddr) && $stable(htrans) && $stable(hsize) &&
       $stable(hburst) && $stable(hwrite))) else $error("hold"); // R3

   AST_HOLD_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && !hresp) |=> $stable(hwdata)) else $error("wdata hold"); // R4

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == 2'b11 && $past(hready) && $past(htrans) != 2'b00) |->
      (haddr == $past(haddr) + (ADDR_W'(1) << $past(hsize)))) else $error("step"); // R1

   AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans == 2'b11) |-> ($past(htrans) != 2'b00)) else $error("order"); // R6

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hresp && !hready) |=> (htrans == 2'b00)) else $error("err idle"); // R7

   AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (htrans != 2'b00) |-> !cmd_ready) else $error("busy"); // R5
endmodule

bind burst_master burst_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .haddr(haddr),
   .htrans(htrans), .hsize(hsize), .hburst(hburst), .hwrite(hwrite),
   .hwdata(hwdata), .hready(hready), .hresp(hresp)
);

// File: tb/burst_master_test.sv
`timescale 1ns/1ps
module burst_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_addr = '0;
   logic [1:0]  cmd_size = '0;
   logic        cmd_write = 1'b0;
   logic [1:0]  cmd_kind = '0;
   logic [4:0]  cmd_count = '0;
   logic [31:0] wr_data;
   logic        wr_pop;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        done_valid;
   logic        done_err;
   logic [31:0] haddr;
   logic [1:0]  htrans;
   logic [2:0]  hsize;
   logic [2:0]  hburst;
   logic        hwrite;
   logic [31:0] hwdata;
   logic [31:0] hrdata;
   logic        hready;
   logic        hresp;

   burst_master uut (.*);

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit ended = 0;

   int ap_n, dp_n, last_dp_cyc, err_beat, err_stage, dp_idx, wr_ptr;
   bit stall_en, dp_on, dp_wr;
   logic [31:0] base, seed;
   logic [1:0]  e_size, e_kind;
   logic        e_wr;
   bit          p_hold;
   logic [31:0] p_addr, p_wdata;
   logic [1:0]  p_trans;
   logic        p_wr;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] wdat(input int k);
      return 32'hA5000000 ^ (seed << 12) ^ (32'(k) * 32'h00010101);
   endfunction
   function automatic logic [31:0] rdat(input int k);
      return 32'hC0DE0000 + (seed << 8) + 32'(k);
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   // slave model: replies driven after each edge, outputs sampled at the falling edge
   initial begin
      hready = 1'b1; hresp = 1'b0; hrdata = '0; wr_data = '0;
      dp_on = 0; err_stage = 0; err_beat = 99; stall_en = 0; p_hold = 0;
      forever begin
         @(posedge clk);
         #1;
         if (err_stage == 1) begin
            hready = 1'b1; hresp = 1'b1; err_stage = 2;
         end else if (dp_on && dp_idx == err_beat && err_stage == 0) begin
            hready = 1'b0; hresp = 1'b1; err_stage = 1;
         end else begin
            hresp  = 1'b0;
            hready = !(stall_en && (cyc % 3 == 1));
         end
         hrdata  = rdat(dp_idx);
         wr_data = wdat(wr_ptr);
         @(negedge clk);
         if (p_hold) begin
            chk(haddr == p_addr && htrans == p_trans && hwrite == p_wr, "R3 address phase held", haddr, p_addr);
            if (dp_on && dp_wr) chk(hwdata == p_wdata, "R4 hwdata held", hwdata, p_wdata);
         end
         p_hold  = rst_n && !hready && htrans != 2'b00 && !hresp;
         p_addr  = haddr; p_trans = htrans; p_wr = hwrite; p_wdata = hwdata;
         if (hready && dp_on) begin
            last_dp_cyc = cyc;
            dp_n++;
            if (hresp) begin
               chk(htrans == 2'b00, "R7 idle in second error cycle", 32'(htrans), 0);
               chk(!rd_valid, "R7 no read return on error", 32'(rd_valid), 0);
            end else if (dp_wr) begin
               chk(hwdata == wdat(dp_idx), "R4 write beat data", hwdata, wdat(dp_idx));
            end else begin
               chk(rd_valid, "R4 read strobe", 32'(rd_valid), 1);
               chk(rd_data == rdat(dp_idx), "R4 read data", rd_data, rdat(dp_idx));
            end
         end
         if (hready) begin
            if (htrans != 2'b00) begin
               chk(htrans == ((ap_n == 0) ? 2'b10 : 2'b11), "R6 transfer type", 32'(htrans), (ap_n == 0) ? 2 : 3);
               chk(haddr == base + (32'(ap_n) << e_size), "R1 beat address", haddr, base + (32'(ap_n) << e_size));
               chk(hsize == {1'b0, e_size} && hburst == {e_kind, 1'b1} && hwrite == e_wr,
                   "R2 control", {25'd0, hsize, hburst, hwrite}, {25'd0, 1'b0, e_size, e_kind, 1'b1, e_wr});
               if (e_wr) begin
                  chk(wr_pop, "R4 write pop", 32'(wr_pop), 1);
                  wr_ptr++;
               end
               dp_on = 1; dp_wr = hwrite; dp_idx = ap_n; ap_n++;
            end else begin
               dp_on = 0;
            end
         end
      end
   end

   task automatic run(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic wr,
                      input logic [1:0] kd, input logic [4:0] cnt, input bit stall, input int ebeat,
                      input bit refused);
      int exp_beats, acc_cyc, dcyc;
      bit got, derr, busy_bad;
      exp_beats = (kd == 0) ? int'(cnt) : (4 << (kd - 1));
      ap_n = 0; dp_n = 0; err_stage = 0; err_beat = ebeat; stall_en = stall;
      wr_ptr = 0; seed = seed + 1; base = a; e_size = sz; e_kind = kd; e_wr = wr;
      @(posedge clk);
      #1;
      cmd_valid = 1'b1; cmd_addr = a; cmd_size = sz; cmd_write = wr; cmd_kind = kd; cmd_count = cnt;
      @(negedge clk);
      chk(cmd_ready, {tag, " R5 ready when idle"}, 32'(cmd_ready), 1);
      acc_cyc = cyc;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      got = 0; derr = 0; dcyc = 0; busy_bad = 0;
      for (int i = 0; i < 400 && !got; i++) begin
         @(negedge clk);
         if (done_valid) begin
            got = 1; dcyc = cyc; derr = done_err;
         end else if (!refused && cmd_ready) begin
            busy_bad = 1;
         end
      end
      #1;
      chk(got, {tag, " R10 done pulse seen"}, 32'(got), 1);
      if (refused) begin
         chk(derr, {tag, " refused with error"}, 32'(derr), 1);
         chk(dcyc == acc_cyc + 1, {tag, " refusal one cycle after take"}, 32'(dcyc), 32'(acc_cyc + 1));
         chk(ap_n == 0, {tag, " no beat on bus"}, 32'(ap_n), 0);
      end else if (ebeat < exp_beats) begin
         chk(derr, {tag, " R7 error reported"}, 32'(derr), 1);
         chk(ap_n == ebeat + 1, {tag, " R7 rest of burst abandoned"}, 32'(ap_n), 32'(ebeat + 1));
         chk(dcyc == last_dp_cyc + 1, {tag, " R7 error done timing"}, 32'(dcyc), 32'(last_dp_cyc + 1));
      end else begin
         chk(!derr, {tag, " R10 clean completion"}, 32'(derr), 0);
         chk(ap_n == exp_beats, {tag, " R2 beat count"}, 32'(ap_n), 32'(exp_beats));
         chk(dp_n == exp_beats, {tag, " R4 data phases"}, 32'(dp_n), 32'(exp_beats));
         chk(dcyc == last_dp_cyc + 1, {tag, " R10 done one cycle after last beat"}, 32'(dcyc), 32'(last_dp_cyc + 1));
         chk(!busy_bad, {tag, " R5 ready low while busy"}, 32'(busy_bad), 0);
      end
      @(negedge clk);
      chk(!done_valid, {tag, " R10 done lasts one cycle"}, 32'(done_valid), 0);
      err_beat = 99; stall_en = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(htrans == 2'b00, "R6 idle after reset", 32'(htrans), 0);
      chk(cmd_ready, "R5 ready after reset", 32'(cmd_ready), 1);
      chk(!done_valid, "R10 no done after reset", 32'(done_valid), 0);
   endtask

   task automatic t_incr4_half_read();  run("R1 incr4 half read",   32'h34,  2'd1, 1'b0, 2'd1, 5'd0, 0, 99, 0); endtask
   task automatic t_incr8_word_write(); run("R3 incr8 word write",  32'h100, 2'd2, 1'b1, 2'd2, 5'd3, 1, 99, 0); endtask
   task automatic t_incr16_byte_read(); run("R3 incr16 byte read",  32'h207, 2'd0, 1'b0, 2'd3, 5'd9, 1, 99, 0); endtask
   task automatic t_open_write();       run("R2 open 5 word write", 32'h40,  2'd2, 1'b1, 2'd0, 5'd5, 0, 99, 0); endtask
   task automatic t_open_read_stall();  run("R2 open 3 half read",  32'h80,  2'd1, 1'b0, 2'd0, 5'd3, 1, 99, 0); endtask
   task automatic t_error_read();       run("R7 error on beat 2",   32'h10,  2'd2, 1'b0, 2'd2, 5'd0, 0, 2,  0); endtask
   task automatic t_error_write();      run("R7 error on beat 0",   32'h20,  2'd2, 1'b1, 2'd1, 5'd0, 0, 0,  0); endtask
   task automatic t_edge_exact();       run("R8 ends at boundary",  32'h3F0, 2'd2, 1'b0, 2'd1, 5'd0, 0, 99, 0); endtask
   task automatic t_cross();            run("R8 crosses boundary",  32'h3F8, 2'd2, 1'b0, 2'd1, 5'd0, 0, 99, 1); endtask
   task automatic t_size_wide();        run("R9 size too wide",     32'h0,   2'd3, 1'b0, 2'd1, 5'd0, 0, 99, 1); endtask
   task automatic t_open_zero();        run("R9 open count zero",   32'h0,   2'd2, 1'b1, 2'd0, 5'd0, 0, 99, 1); endtask

   initial begin
      seed = 32'd0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_incr4_half_read();
      t_incr8_word_write();
      t_incr16_byte_read();
      t_open_write();
      t_open_read_stall();
      t_error_read();
      t_error_write();
      t_edge_exact();
      t_cross();
      t_size_wide();
      t_open_zero();
      t_incr4_half_read();
      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule